// File: doc/BRIEF.md
# Exception Entry State Sequencer

This block commits the control-state changes a processor core makes when it takes a trap. The pipeline raises a one-cycle take pulse together with a 15-bit cause code, a refill flag, the faulting PC and the instruction word that was fetched. On the next clock edge the block updates all affected registers together. It also produces a one-cycle redirect strobe and the new fetch address.

Each trap follows one of three save paths. Ordinary traps save the mode into a saved-mode register and record the cause. Translation-refill traps save the mode into a separate refill register, force direct addressing and keep a word index of the return PC. Debug entries record their cause in a debug register and leave the ordinary trap state untouched. A debug entry is taken for a breakpoint, or for an interrupt that arrives while the debug-state flag is set.

The core's mode writes reach the mode register through a load port whenever no trap is being taken. The two entry bases and the vector spacing are inputs from the configuration state.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset: privilege 0, interrupt enable 0, direct-address 1, paging 0, debug flags 0, all saved and captured registers 0, redirect strobe 0 and redirect PC 0x1C000000.
- R2: On a take that does not follow the debug path, privilege and interrupt enable become 0 one cycle later. A mode load in the same cycle as any take is discarded.
- R3: Ordinary path (neither debug nor refill). The mode before the take is copied to the saved-mode outputs and the PC goes to the return-address output. The status fields receive code bits [5:0] as the main code and bits [14:6] as the sub-code. The redirect PC is entry base + main × (4 << spacing) when spacing is non-zero, and the entry base when spacing is 0.
- R4: Refill path (refill flag set, not debug). The mode goes to the refill saved-mode outputs, direct-address becomes 1 and paging 0, and the refill return output holds PC >> 2. The redirect PC is the refill entry input. The ordinary saved-mode, return-address and status outputs keep their values.
- R5: Main code 26 is a debug breakpoint and wins over the refill flag. It sets the breakpoint bit and the debug-state flag, sets the debug cause field to 0xC and copies the PC to the debug return output. The redirect PC is entry base + 0x480. Mode, ordinary and refill save state do not change.
- R6: A take with main code 0 (interrupt) while the debug-state flag is set sets the debug-interrupt bit. It copies the PC to the debug return output and redirects to entry base + 0x480. The debug cause field, mode and ordinary save state do not change. With the flag clear, an interrupt follows the ordinary path.
- R7: On a non-debug take, the bad-address output is loaded with the PC for main codes 11 to 18 inclusive. For every other code it keeps its value.
- R8: On a non-debug take, the bad-instruction output captures the instruction word. Main code 0, main code 3, and main code 8 with sub-code 0 are excluded and keep the old value. Debug entries never capture.
- R9: Without a take, a mode load writes privilege, interrupt enable, direct-address and paging one cycle later.
- R10: The redirect strobe is high for exactly the one cycle after each take and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | One-cycle trap take pulse |
| code_i | input | 15 | Cause: [5:0] main code, [14:6] sub-code |
| refill_i | input | 1 | Trap is a translation refill |
| pc_i | input | 64 | Faulting PC |
| insn_i | input | 32 | Fetched instruction word |
| entry_base_i | input | 64 | Ordinary and debug entry base |
| refill_entry_i | input | 64 | Refill entry address |
| vec_spacing_i | input | 3 | Vector spacing exponent (0 = single entry) |
| mode_ld_i | input | 1 | Load mode register |
| mode_plv_i | input | 2 | Privilege to load |
| mode_ie_i | input | 1 | Interrupt enable to load |
| mode_da_i | input | 1 | Direct-address bit to load |
| mode_pg_i | input | 1 | Paging bit to load |
| plv_o | output | 2 | Current privilege |
| ie_o | output | 1 | Current interrupt enable |
| da_o | output | 1 | Direct-address mode |
| pg_o | output | 1 | Paging mode |
| prmd_plv_o | output | 2 | Saved privilege (ordinary) |
| prmd_ie_o | output | 1 | Saved interrupt enable (ordinary) |
| era_o | output | 64 | Return address (ordinary) |
| stat_main_o | output | 6 | Status main code |
| stat_sub_o | output | 9 | Status sub-code |
| rf_plv_o | output | 2 | Saved privilege (refill) |
| rf_ie_o | output | 1 | Saved interrupt enable (refill) |
| refill_ret_o | output | 64 | Refill return word index (PC >> 2) |
| badv_o | output | 64 | Bad address |
| badi_o | output | 32 | Bad instruction |
| dbg_state_o | output | 1 | Debug-state flag |
| dbg_bp_o | output | 1 | Debug breakpoint cause bit |
| dbg_int_o | output | 1 | Debug interrupt bit |
| dbg_cause_o | output | 6 | Debug cause code |
| dbg_ret_o | output | 64 | Debug return address |
| redirect_o | output | 1 | Redirect strobe |
| redirect_pc_o | output | 64 | New fetch address |

## Verification
The bench sweeps every main code against every vector spacing, with the refill flag both set and clear. A design that shifted by the wrong amount, or scaled when the spacing is 0, would send traps to the wrong vector. A design that mixed up the save paths would overwrite the ordinary return address on a refill, or drop the low PC bits in the wrong place. The bench separates sub-code 0 from sub-code 1 under main code 8 and probes the edges 10/11 and 18/19 of the bad-address window; an off-by-one range or a test on the main code alone fails there. It also checks interrupts before and after a breakpoint sets the debug-state flag, a breakpoint taken with the refill flag set, and a mode load in the same cycle as a take. A design that ignored the flag, let refill win over debug or let the load win would leave the wrong mode or debug bits.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN = 64,
  parameter int IW = 32,
  parameter int MAIN_W = 6,
  parameter int SUB_W = 9,
  parameter int VS_W = 3,
  parameter logic [63:0] RESET_PC = 64'h1C00_0000,
  parameter int DBG_OFS = 'h480,
  parameter int BP_CODE = 26,
  parameter int DBG_CAUSE = 'hC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take_i,
  input  logic [MAIN_W+SUB_W-1:0]  code_i,
  input  logic                     refill_i,
  input  logic [XLEN-1:0]          pc_i,
  input  logic [IW-1:0]            insn_i,
  input  logic [XLEN-1:0]          entry_base_i,
  input  logic [XLEN-1:0]          refill_entry_i,
  input  logic [VS_W-1:0]          vec_spacing_i,
  input  logic                     mode_ld_i,
  input  logic [1:0]               mode_plv_i,
  input  logic                     mode_ie_i,
  input  logic                     mode_da_i,
  input  logic                     mode_pg_i,
  output logic [1:0]               plv_o,
  output logic                     ie_o,
  output logic                     da_o,
  output logic                     pg_o,
  output logic [1:0]               prmd_plv_o,
  output logic                     prmd_ie_o,
  output logic [XLEN-1:0]          era_o,
  output logic [MAIN_W-1:0]        stat_main_o,
  output logic [SUB_W-1:0]         stat_sub_o,
  output logic [1:0]               rf_plv_o,
  output logic                     rf_ie_o,
  output logic [XLEN-1:0]          refill_ret_o,
  output logic [XLEN-1:0]          badv_o,
  output logic [IW-1:0]            badi_o,
  output logic                     dbg_state_o,
  output logic                     dbg_bp_o,
  output logic                     dbg_int_o,
  output logic [MAIN_W-1:0]        dbg_cause_o,
  output logic [XLEN-1:0]          dbg_ret_o,
  output logic                     redirect_o,
  output logic [XLEN-1:0]          redirect_pc_o
);
  localparam int CW = MAIN_W + SUB_W;
  localparam int SH_W = VS_W + 2;
  localparam logic [MAIN_W-1:0] C_INT      = '0;
  localparam logic [MAIN_W-1:0] C_FETCH_PI = MAIN_W'(3);
  localparam logic [MAIN_W-1:0] C_ADDR     = MAIN_W'(8);
  localparam logic [MAIN_W-1:0] C_BADV_LO  = MAIN_W'(11);
  localparam logic [MAIN_W-1:0] C_BADV_HI  = MAIN_W'(18);
  localparam logic [MAIN_W-1:0] C_BP       = MAIN_W'(BP_CODE);

  logic [MAIN_W-1:0] main_c;
  logic [SUB_W-1:0]  sub_c;
  logic dbg_go, refill_go, normal_go, badv_go, badi_go, silent_cause;
  logic [XLEN-1:0] vec_ofs, normal_target, dbg_target;

  assign main_c = code_i[MAIN_W-1:0];
  assign sub_c  = code_i[CW-1:MAIN_W];

  assign dbg_go    = take_i & ((main_c == C_BP) | ((main_c == C_INT) & dbg_state_o));
  assign refill_go = take_i & ~dbg_go & refill_i;
  assign normal_go = take_i & ~dbg_go & ~refill_i;

  assign silent_cause = (main_c == C_INT) | (main_c == C_FETCH_PI) |
                        ((main_c == C_ADDR) & (sub_c == '0));
  assign badv_go = take_i & ~dbg_go & (main_c >= C_BADV_LO) & (main_c <= C_BADV_HI);
  assign badi_go = take_i & ~dbg_go & ~silent_cause;

  assign vec_ofs = (vec_spacing_i == '0) ? '0
                 : (XLEN'(main_c) << ({2'b00, vec_spacing_i} + SH_W'(2)));
  assign normal_target = entry_base_i + vec_ofs;
  assign dbg_target    = entry_base_i + XLEN'(DBG_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plv_o <= '0;
      ie_o  <= 1'b0;
      da_o  <= 1'b1;
      pg_o  <= 1'b0;
    end else if (take_i) begin
      if (!dbg_go) begin
        plv_o <= '0;
        ie_o  <= 1'b0;
      end
      if (refill_go) begin
        da_o <= 1'b1;
        pg_o <= 1'b0;
      end
    end else if (mode_ld_i) begin
      plv_o <= mode_plv_i;
      ie_o  <= mode_ie_i;
      da_o  <= mode_da_i;
      pg_o  <= mode_pg_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prmd_plv_o  <= '0;
      prmd_ie_o   <= 1'b0;
      era_o       <= '0;
      stat_main_o <= '0;
      stat_sub_o  <= '0;
    end else if (normal_go) begin
      prmd_plv_o  <= plv_o;
      prmd_ie_o   <= ie_o;
      era_o       <= pc_i;
      stat_main_o <= main_c;
      stat_sub_o  <= sub_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_plv_o     <= '0;
      rf_ie_o      <= 1'b0;
      refill_ret_o <= '0;
    end else if (refill_go) begin
      rf_plv_o     <= plv_o;
      rf_ie_o      <= ie_o;
      refill_ret_o <= pc_i >> 2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badv_o <= '0;
      badi_o <= '0;
    end else begin
      if (badv_go) badv_o <= pc_i;
      if (badi_go) badi_o <= insn_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_state_o <= 1'b0;
      dbg_bp_o    <= 1'b0;
      dbg_int_o   <= 1'b0;
      dbg_cause_o <= '0;
      dbg_ret_o   <= '0;
    end else if (dbg_go) begin
      dbg_state_o <= 1'b1;
      dbg_ret_o   <= pc_i;
      if (main_c == C_BP) begin
        dbg_bp_o    <= 1'b1;
        dbg_cause_o <= MAIN_W'(DBG_CAUSE);
      end else begin
        dbg_int_o <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= XLEN'(RESET_PC);
    end else begin
      redirect_o <= take_i;
      if (dbg_go)         redirect_pc_o <= dbg_target;
      else if (refill_go) redirect_pc_o <= refill_entry_i;
      else if (normal_go) redirect_pc_o <= normal_target;
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int XLEN = 64,
  parameter int MAIN_W = 6,
  parameter int SUB_W = 9,
  parameter int DBG_OFS = 'h480,
  parameter int BP_CODE = 26,
  parameter int DBG_CAUSE = 'hC
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    take_i,
  input logic [MAIN_W+SUB_W-1:0] code_i,
  input logic                    refill_i,
  input logic [XLEN-1:0]         pc_i,
  input logic [XLEN-1:0]         entry_base_i,
  input logic [XLEN-1:0]         refill_entry_i,
  input logic [1:0]              plv_o,
  input logic                    ie_o,
  input logic                    da_o,
  input logic                    pg_o,
  input logic [1:0]              prmd_plv_o,
  input logic                    prmd_ie_o,
  input logic [XLEN-1:0]         era_o,
  input logic [MAIN_W-1:0]       stat_main_o,
  input logic [SUB_W-1:0]        stat_sub_o,
  input logic [XLEN-1:0]         refill_ret_o,
  input logic                    dbg_state_o,
  input logic                    dbg_bp_o,
  input logic                    dbg_int_o,
  input logic [MAIN_W-1:0]       dbg_cause_o,
  input logic [XLEN-1:0]         dbg_ret_o,
  input logic                    redirect_o,
  input logic [XLEN-1:0]         redirect_pc_o
);
  logic is_bp, is_int, dpath, rpath, npath;
  assign is_bp  = code_i[MAIN_W-1:0] == MAIN_W'(BP_CODE);
  assign is_int = code_i[MAIN_W-1:0] == '0;
  assign dpath  = is_bp | (is_int & dbg_state_o);
  assign rpath  = ~dpath & refill_i;
  assign npath  = ~dpath & ~refill_i;

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !dpath |=> plv_o == 2'd0 && !ie_o); // R2

  AST_NORMAL_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && npath |=> prmd_plv_o == $past(plv_o) && prmd_ie_o == $past(ie_o) &&
                        era_o == $past(pc_i) && stat_main_o == $past(code_i[MAIN_W-1:0]) &&
                        stat_sub_o == $past(code_i[MAIN_W+SUB_W-1:MAIN_W])); // R3

  AST_REFILL_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && rpath |=> da_o && !pg_o && refill_ret_o == ($past(pc_i) >> 2) &&
                        redirect_pc_o == $past(refill_entry_i) && $stable(era_o)); // R4

  AST_DEBUG_BP: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && is_bp |=> dbg_state_o && dbg_bp_o && dbg_cause_o == MAIN_W'(DBG_CAUSE) &&
                        dbg_ret_o == $past(pc_i) &&
                        redirect_pc_o == $past(entry_base_i) + XLEN'(DBG_OFS)); // R5

  AST_DEBUG_INT: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && is_int && dbg_state_o |=> dbg_int_o && $stable(plv_o) && $stable(era_o) &&
                                         dbg_ret_o == $past(pc_i)); // R6

  AST_REDIRECT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> redirect_o); // R10

  AST_REDIRECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> $past(take_i)); // R10
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .XLEN(XLEN), .MAIN_W(MAIN_W), .SUB_W(SUB_W),
  .DBG_OFS(DBG_OFS), .BP_CODE(BP_CODE), .DBG_CAUSE(DBG_CAUSE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .take_i(take_i), .code_i(code_i), .refill_i(refill_i),
  .pc_i(pc_i), .entry_base_i(entry_base_i), .refill_entry_i(refill_entry_i),
  .plv_o(plv_o), .ie_o(ie_o), .da_o(da_o), .pg_o(pg_o),
  .prmd_plv_o(prmd_plv_o), .prmd_ie_o(prmd_ie_o), .era_o(era_o),
  .stat_main_o(stat_main_o), .stat_sub_o(stat_sub_o), .refill_ret_o(refill_ret_o),
  .dbg_state_o(dbg_state_o), .dbg_bp_o(dbg_bp_o), .dbg_int_o(dbg_int_o),
  .dbg_cause_o(dbg_cause_o), .dbg_ret_o(dbg_ret_o),
  .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic take_i = 1'b0;
  logic [14:0] code_i = '0;
  logic refill_i = 1'b0;
  logic [63:0] pc_i = '0;
  logic [31:0] insn_i = '0;
  logic [63:0] entry_base_i = 64'h9000_0000_0460_0000;
  logic [63:0] refill_entry_i = 64'h9000_0000_0046_b000;
  logic [2:0] vec_spacing_i = '0;
  logic mode_ld_i = 1'b0;
  logic [1:0] mode_plv_i = '0;
  logic mode_ie_i = 1'b0, mode_da_i = 1'b0, mode_pg_i = 1'b0;

  logic [1:0] plv_o, prmd_plv_o, rf_plv_o;
  logic ie_o, da_o, pg_o, prmd_ie_o, rf_ie_o;
  logic [63:0] era_o, refill_ret_o, badv_o, dbg_ret_o, redirect_pc_o;
  logic [5:0] stat_main_o, dbg_cause_o;
  logic [8:0] stat_sub_o;
  logic [31:0] badi_o;
  logic dbg_state_o, dbg_bp_o, dbg_int_o, redirect_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .code_i(code_i), .refill_i(refill_i),
    .pc_i(pc_i), .insn_i(insn_i), .entry_base_i(entry_base_i),
    .refill_entry_i(refill_entry_i), .vec_spacing_i(vec_spacing_i),
    .mode_ld_i(mode_ld_i), .mode_plv_i(mode_plv_i), .mode_ie_i(mode_ie_i),
    .mode_da_i(mode_da_i), .mode_pg_i(mode_pg_i),
    .plv_o(plv_o), .ie_o(ie_o), .da_o(da_o), .pg_o(pg_o),
    .prmd_plv_o(prmd_plv_o), .prmd_ie_o(prmd_ie_o), .era_o(era_o),
    .stat_main_o(stat_main_o), .stat_sub_o(stat_sub_o),
    .rf_plv_o(rf_plv_o), .rf_ie_o(rf_ie_o), .refill_ret_o(refill_ret_o),
    .badv_o(badv_o), .badi_o(badi_o),
    .dbg_state_o(dbg_state_o), .dbg_bp_o(dbg_bp_o), .dbg_int_o(dbg_int_o),
    .dbg_cause_o(dbg_cause_o), .dbg_ret_o(dbg_ret_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  int n_checks = 0;
  int n_fail = 0;

  logic [1:0] m_plv, m_pplv, m_rplv;
  logic m_ie, m_da, m_pg, m_pie, m_rie, m_dst, m_dbp, m_dint;
  logic [63:0] m_era, m_rret, m_badv, m_dret, m_pc;
  logic [5:0] m_smain, m_dcause;
  logic [8:0] m_ssub;
  logic [31:0] m_badi;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_plv = 0; m_ie = 0; m_da = 1; m_pg = 0;
    m_pplv = 0; m_pie = 0; m_era = 0; m_smain = 0; m_ssub = 0;
    m_rplv = 0; m_rie = 0; m_rret = 0; m_badv = 0; m_badi = 0;
    m_dst = 0; m_dbp = 0; m_dint = 0; m_dcause = 0; m_dret = 0;
    m_pc = 64'h1C00_0000;
  endtask

  task automatic compare_all(input string pcreq);
    chk("R2", "plv", 64'(plv_o), 64'(m_plv));
    chk("R2", "ie", 64'(ie_o), 64'(m_ie));
    chk("R4", "da/pg", 64'({da_o, pg_o}), 64'({m_da, m_pg}));
    chk("R3", "saved mode", 64'({prmd_plv_o, prmd_ie_o}), 64'({m_pplv, m_pie}));
    chk("R3", "return addr", era_o, m_era);
    chk("R3", "status", 64'({stat_sub_o, stat_main_o}), 64'({m_ssub, m_smain}));
    chk("R4", "refill saved mode", 64'({rf_plv_o, rf_ie_o}), 64'({m_rplv, m_rie}));
    chk("R4", "refill return", refill_ret_o, m_rret);
    chk("R7", "bad addr", badv_o, m_badv);
    chk("R8", "bad insn", 64'(badi_o), 64'(m_badi));
    chk("R5", "debug bits", 64'({dbg_state_o, dbg_bp_o, dbg_cause_o}), 64'({m_dst, m_dbp, m_dcause}));
    chk("R6", "debug int", 64'(dbg_int_o), 64'(m_dint));
    chk("R5", "debug return", dbg_ret_o, m_dret);
    chk(pcreq, "redirect pc", redirect_pc_o, m_pc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    take_i = 1'b0;
    mode_ld_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    compare_all("R1");
    chk("R1", "redirect strobe", 64'(redirect_o), 64'd0);
  endtask

  task automatic load_mode(input logic [1:0] p, input logic i, input logic d, input logic g);
    @(negedge clk);
    mode_ld_i = 1'b1; mode_plv_i = p; mode_ie_i = i; mode_da_i = d; mode_pg_i = g;
    @(negedge clk);
    mode_ld_i = 1'b0;
    m_plv = p; m_ie = i; m_da = d; m_pg = g;
    chk("R9", "mode load", 64'({plv_o, ie_o, da_o, pg_o}), 64'({p, i, d, g}));
  endtask

  task automatic take(input logic [5:0] mc, input logic [8:0] sc, input logic rf,
                      input logic [63:0] pc, input logic [31:0] insn, input logic [2:0] vs,
                      input logic with_load);
    logic dpath;
    string pcreq;
    @(negedge clk);
    code_i = {sc, mc}; refill_i = rf; pc_i = pc; insn_i = insn; vec_spacing_i = vs;
    take_i = 1'b1;
    if (with_load) begin
      mode_ld_i = 1'b1; mode_plv_i = 2'd3; mode_ie_i = 1'b1; mode_da_i = 1'b0; mode_pg_i = 1'b1;
    end
    @(negedge clk);
    take_i = 1'b0;
    mode_ld_i = 1'b0;
    dpath = (mc == 6'd26) || (mc == 6'd0 && m_dst);
    if (dpath) begin
      m_dret = pc; m_dst = 1;
      if (mc == 6'd26) begin m_dbp = 1; m_dcause = 6'hC; pcreq = "R5"; end
      else begin m_dint = 1; pcreq = "R6"; end
      m_pc = entry_base_i + 64'h480;
    end else begin
      if (mc >= 11 && mc <= 18) m_badv = pc;
      if (!(mc == 0 || mc == 3 || (mc == 8 && sc == 0))) m_badi = insn;
      if (rf) begin
        m_rplv = m_plv; m_rie = m_ie; m_da = 1; m_pg = 0; m_rret = pc >> 2;
        m_pc = refill_entry_i; pcreq = "R4";
      end else begin
        m_pplv = m_plv; m_pie = m_ie; m_era = pc; m_smain = mc; m_ssub = sc;
        m_pc = entry_base_i + ((vs == 0) ? 64'd0 : 64'(mc) * (64'd4 << vs));
        pcreq = "R3";
      end
      m_plv = 0; m_ie = 0;
    end
    chk("R10", "strobe high", 64'(redirect_o), 64'd1);
    compare_all(pcreq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    load_mode(2'd2, 1'b1, 1'b0, 1'b1);

    // R3 R4 R7 R8: sweep all non-breakpoint codes, spacings, both refill settings
    for (int mc = 0; mc < 64; mc++) begin
      if (mc == 26) continue;
      for (int vs = 0; vs < 8; vs++) begin
        for (int rf = 0; rf < 2; rf++) begin
          load_mode(2'(mc + vs), 1'(vs), 1'b0, 1'b1);
          take(6'(mc), 9'((vs * 37 + rf) & 9'h1ff), 1'(rf),
               64'h9000_0000_0000_0002 | (64'(mc) << 12) | (64'(vs) << 5) | (64'(rf) << 4),
               32'hA500_0000 ^ 32'(mc * 1031 + vs * 17 + rf), 3'(vs), 1'b0);
        end
      end
    end
    @(negedge clk);
    chk("R10", "strobe low", 64'(redirect_o), 64'd0);

    // R2: mode load during a take is discarded
    load_mode(2'd1, 1'b1, 1'b0, 1'b1);
    take(6'd11, 9'd0, 1'b0, 64'h1234_5678, 32'hDEAD_BEEF, 3'd2, 1'b1);

    // R6: interrupt before debug state follows ordinary path
    load_mode(2'd3, 1'b1, 1'b0, 1'b1);
    take(6'd0, 9'd0, 1'b0, 64'hAAAA_0000, 32'h1111_1111, 3'd1, 1'b0);

    // R5: breakpoint with refill flag set still takes debug path
    load_mode(2'd3, 1'b1, 1'b0, 1'b1);
    take(6'd26, 9'd0, 1'b1, 64'hBBBB_0004, 32'h2222_2222, 3'd3, 1'b0);
    chk("R5", "mode kept", 64'({plv_o, ie_o, da_o, pg_o}), 64'({2'd3, 1'b1, 1'b0, 1'b1}));

    // R6: interrupt in debug state
    take(6'd0, 9'd0, 1'b0, 64'hCCCC_0008, 32'h3333_3333, 3'd3, 1'b0);
    // non-interrupt in debug state stays ordinary
    take(6'd12, 9'd5, 1'b0, 64'hDDDD_000C, 32'h4444_4444, 3'd4, 1'b0);

    // R1: reset again restores everything
    do_reset();
    take(6'd26, 9'd3, 1'b0, 64'hEEEE_0010, 32'h5555_5555, 3'd0, 1'b0);
    take(6'd0, 9'd0, 1'b1, 64'hFFFF_0014, 32'h6666_6666, 3'd0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule